// File: doc/BRIEF.md
# I2C Read-Responding Slave with Acknowledge-Clock Stretching

This block is the target side of an I2C link that answers read transfers sent to its own 7-bit address. Both bus lines arrive as oversampled inputs and pass through a synchronizer clocked by the system clock. The block drives the bus only through two pull-low outputs, which model open-drain drivers. It finds start and stop conditions, shifts in the address byte and acknowledges a match. When the direction bit asks for a read, it enters transmit mode and sends bytes that the CPU supplies through a data-write strobe.

At the end of every acknowledge clock, after the address and after each transmitted byte, the block raises an interrupt request. It then holds SCL low until the CPU writes the data register. This write is needed even after the master has answered NACK to the last byte. In that case the data is discarded and the write only frees the clock. An arbitration-lost input forces the mode flag to receive at address decode, whatever the direction bit says. The CPU can read the captured address byte and use a force input to select transmit mode before it writes the first byte.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset, scl_pull_o, sda_pull_o, irq_o and tx_mode_o are 0 and addr_byte_o is 0.
- R2: After a start, eight address bits are sampled on rising SCL edges, MSB first, into addr_byte_o. Bits 7:1 are compared with own_addr_i, and bit 0 is the direction bit (1 = read). On a match the block pulls SDA low for the ninth clock. On a mismatch it never pulls either line and raises no interrupt.
- R3: On a matched address, tx_mode_o becomes 1 when bit 0 is 1 and 0 when bit 0 is 0. In receive mode the block does not drive SDA after the data write.
- R4: irq_o is set at the falling SCL edge that ends each acknowledge clock, for the address and for every transmitted byte. It stays set until irq_clr_i is high at a clock edge.
- R5: From the falling SCL edge that ends an acknowledge clock, scl_pull_o stays 1 for as long as data_wr_i is low, so the SCL line remains low. It returns to 0 on the clock edge that samples data_wr_i high.
- R6: A byte loaded by the data write is sent MSB first. The first bit is driven immediately, and each later bit after a falling SCL edge. SDA is never changed while the synchronized SCL is high. The block releases SDA for the master's acknowledge bit.
- R7: The acknowledge bit is sampled on its rising SCL edge. After a NACK the clock is still held, and the following data write only releases SCL. The block then leaves SDA released until the next start.
- R8: If arb_lost_i is high when the address is decoded, tx_mode_o is 0 even for a read, and addr_byte_o still shows the received byte. A pulse on force_tx_i during the hold sets tx_mode_o to 1, and the next data write transmits.
- R9: A stop condition returns the block to idle. A repeated start begins a new address phase. Both clear tx_mode_o and release both lines.
- R10: data_wr_i and irq_clr_i given while the block is idle change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | DATA_W-1 | Own 7-bit address |
| data_wr_i | input | 1 | CPU write strobe for the transmit data register |
| data_i | input | DATA_W | Transmit data |
| force_tx_i | input | 1 | CPU request to select transmit mode during the hold |
| arb_lost_i | input | 1 | Arbitration-lost flag |
| irq_clr_i | input | 1 | Clears the pending interrupt |
| irq_o | output | 1 | Interrupt request |
| tx_mode_o | output | 1 | Mode flag, 1 = transmit |
| addr_byte_o | output | DATA_W | Last received address byte |

## Verification
A change on either bus line passes through two synchronizer flops and one edge flop. The pull outputs, the mode flag and the interrupt therefore settle on the third clock edge after the line moves. The CPU-side strobes act one edge after they are sampled: data_wr_i releases SCL, and irq_clr_i or force_tx_i updates its output. The bench model of the master waits eight cycles after every line change before it moves or samples again, which leaves a margin well past the three-edge latency. CPU-side results are checked on the falling clock edge right after the strobe, where the one-edge response is due.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ADDR_ACK,
    ST_TX_BIT,
    ST_TX_ACK,
    ST_HOLD,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] lines_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES:0] pipe_q;
    // bus idles high, so reset to 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-1:0], lines_i[l]};
    end
    assign lines_o[l] = pipe_q[STAGES-1];
    assign rise_o[l]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[l]  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic scl_s_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  assign start_o = scl_s_i & sda_fall_i;
  assign stop_o  = scl_s_i & sda_rise_i;
endmodule

// File: rtl/i2c_tx_shift.sv
module i2c_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end
  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              force_tx_i,
  input  logic              arb_lost_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              tx_mode_o,
  output logic [DATA_W-1:0] addr_byte_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [1:0] sync_w, rise_w, fall_w;
  logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
  logic start, stop;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i ({sda_i, scl_i}),
    .lines_o (sync_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );
  assign scl_s    = sync_w[0];
  assign sda_s    = sync_w[1];
  assign scl_rise = rise_w[0];
  assign scl_fall = fall_w[0];
  assign sda_rise = rise_w[1];
  assign sda_fall = fall_w[1];

  i2c_cond_det u_cond (
    .scl_s_i    (scl_s),
    .sda_rise_i (sda_rise),
    .sda_fall_i (sda_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sr_q;
  logic              mode_q, ack_q, nack_q, irq_q;
  logic              tx_ok, tx_load, tx_shift, tx_msb, ack_end, addr_match;

  assign addr_match = rx_sr_q[DATA_W-1:1] == own_addr_i;
  assign tx_ok      = (mode_q | force_tx_i) & ~nack_q;
  assign tx_load    = (state_q == ST_HOLD) & data_wr_i & tx_ok;
  assign tx_shift   = (state_q == ST_TX_BIT) & scl_fall & (cnt_q != LAST_BIT);
  assign ack_end    = scl_fall & ((state_q == ST_ADDR_ACK) | (state_q == ST_TX_ACK));

  i2c_tx_shift #(.W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load),
    .shift_i (tx_shift),
    .data_i  (data_i),
    .msb_o   (tx_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_sr_q <= '0;
      mode_q  <= 1'b0;
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else if (start) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          rx_sr_q <= {rx_sr_q[DATA_W-2:0], sda_s};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_q <= ST_ADDR_END;
        end
        ST_ADDR_END: if (scl_fall) begin
          if (addr_match) begin
            ack_q   <= 1'b1;
            mode_q  <= rx_sr_q[0] & ~arb_lost_i;
            state_q <= ST_ADDR_ACK;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          ack_q   <= 1'b0;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (force_tx_i) mode_q <= 1'b1;
          if (data_wr_i) begin
            cnt_q   <= '0;
            state_q <= tx_ok ? ST_TX_BIT : ST_SKIP;
          end
        end
        ST_TX_BIT: if (scl_fall) begin
          if (cnt_q == LAST_BIT) state_q <= ST_TX_ACK;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        ST_TX_ACK: begin
          if (scl_rise) nack_q  <= sda_s;
          if (scl_fall) state_q <= ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (ack_end)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign scl_pull_o  = state_q == ST_HOLD;
  assign sda_pull_o  = ack_q | ((state_q == ST_TX_BIT) & ~tx_msb);
  assign irq_o       = irq_q;
  assign tx_mode_o   = mode_q;
  assign addr_byte_o = rx_sr_q;
endmodule

// File: rtl/i2c_slave_tx_chk.sv
module i2c_slave_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic irq_o,
  input logic data_wr_i,
  input logic irq_clr_i,
  input logic scl_s_i
);
  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o && !data_wr_i |=> scl_pull_o); // R5

  AST_STRETCH_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o && data_wr_i |=> !scl_pull_o); // R5

  AST_STRETCH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pull_o) |-> irq_o); // R4

  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && irq_clr_i && scl_pull_o |=> !irq_o); // R4

  AST_SDA_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s_i)); // R6
endmodule

bind i2c_slave_tx i2c_slave_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .irq_o      (irq_o),
  .data_wr_i  (data_wr_i),
  .irq_clr_i  (irq_clr_i),
  .scl_s_i    (scl_s)
);

// File: tb/sim_i2c_slave_tx.sv
module sim_i2c_slave_tx;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, m_scl_low, m_sda_low;
  logic scl_pull, sda_pull, data_wr, force_tx, arb_lost, irq_clr, irq, tx_mode;
  logic [7:0] data, addr_byte;
  logic scl_line, sda_line;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  assign scl_line = ~(m_scl_low | scl_pull);
  assign sda_line = ~(m_sda_low | sda_pull);

  i2c_slave_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .own_addr_i(OWN),
    .data_wr_i(data_wr), .data_i(data), .force_tx_i(force_tx),
    .arb_lost_i(arb_lost), .irq_clr_i(irq_clr), .irq_o(irq),
    .tx_mode_o(tx_mode), .addr_byte_o(addr_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b1; wcyc(Q);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    m_sda_low = 1'b0; wcyc(2 * Q);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda_low = ~b; wcyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); wcyc(Q);
    r = sda_line; wcyc(Q);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic m_send(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ack);
  endtask

  task automatic m_read(input logic nack, output logic [7:0] d, output logic ack_seen);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(nack, ack_seen);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); data = d; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic cpu_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // master lets go of SCL, the line must stay low while the slave holds it
  task automatic probe_stretch(input string req);
    m_scl_low = 1'b0; wcyc(40);
    chk(req, scl_line, 1'b0);
    m_scl_low = 1'b1; wcyc(Q);
  endtask

  task automatic t_reset();
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_mode", tx_mode, 0);
    chk("R1 addr_byte", addr_byte, 0);
  endtask

  task automatic t_idle_write();
    cpu_write(8'h00);
    chk("R10 scl_pull after idle write", scl_pull, 0);
    wcyc(4);
    chk("R10 sda_pull after idle write", sda_pull, 0);
    cpu_clr();
    chk("R10 irq after idle clear", irq, 0);
    chk("R10 tx_mode idle", tx_mode, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    m_start();
    m_send({OWN ^ 7'h01, 1'b1}, a);
    chk("R2 mismatch no ack", a, 1);
    chk("R2 mismatch no irq", irq, 0);
    chk("R2 mismatch no stretch", scl_pull, 0);
    chk("R2 addr_byte captured", addr_byte, {OWN ^ 7'h01, 1'b1});
    m_stop();
  endtask

  task automatic t_read_two();
    logic a, s;
    logic [7:0] rb;
    m_start();
    m_send({OWN, 1'b1}, a);
    chk("R2 match ack", a, 0);
    chk("R3 read sets tx_mode", tx_mode, 1);
    chk("R4 irq after address", irq, 1);
    chk("R5 stretch after address", scl_pull, 1);
    probe_stretch("R5 SCL held low");
    cpu_clr();
    chk("R4 irq cleared", irq, 0);
    chk("R5 still held after clear", scl_pull, 1);
    cpu_write(8'hA5);
    chk("R5 release after write", scl_pull, 0);
    m_read(1'b0, rb, s);
    chk("R6 first byte MSB first", rb, 8'hA5);
    chk("R4 irq after byte", irq, 1);
    chk("R5 stretch after byte", scl_pull, 1);
    cpu_clr();
    cpu_write(8'h3C);
    m_read(1'b1, rb, s);
    chk("R6 second byte", rb, 8'h3C);
    chk("R6 SDA released in ack bit", s, 1);
    chk("R7 stretch after NACK", scl_pull, 1);
    chk("R4 irq after last byte", irq, 1);
    probe_stretch("R7 SCL held after NACK");
    cpu_write(8'h00);
    chk("R7 dummy write releases SCL", scl_pull, 0);
    chk("R7 dummy data not driven", sda_pull, 0);
    m_bit(1'b1, s);
    chk("R7 SDA stays released", s, 1);
    m_stop();
    chk("R9 stop clears tx_mode", tx_mode, 0);
    chk("R9 stop releases SDA", sda_pull, 0);
    cpu_clr();
  endtask

  task automatic t_write_dir();
    logic a, s;
    m_start();
    m_send({OWN, 1'b0}, a);
    chk("R2 write-direction ack", a, 0);
    chk("R3 write keeps tx_mode 0", tx_mode, 0);
    chk("R4 irq after write address", irq, 1);
    chk("R5 stretch write address", scl_pull, 1);
    cpu_write(8'h00);
    chk("R5 release after write", scl_pull, 0);
    m_bit(1'b1, s);
    chk("R3 receive mode does not drive", s, 1);
    m_stop();
    cpu_clr();
  endtask

  task automatic t_arb_lost();
    logic a, s;
    logic [7:0] rb;
    arb_lost = 1'b1;
    m_start();
    m_send({OWN, 1'b1}, a);
    arb_lost = 1'b0;
    chk("R8 ack despite arb lost", a, 0);
    chk("R8 arb lost forces receive", tx_mode, 0);
    chk("R8 address byte read bit", addr_byte, {OWN, 1'b1});
    @(negedge clk); force_tx = 1'b1;
    @(negedge clk); force_tx = 1'b0;
    chk("R8 force sets tx_mode", tx_mode, 1);
    cpu_clr();
    cpu_write(8'h5A);
    m_read(1'b1, rb, s);
    chk("R8 byte after forced transmit", rb, 8'h5A);
    cpu_write(8'hFF);
    m_stop();
    chk("R9 stop after forced transmit", tx_mode, 0);
    cpu_clr();
  endtask

  task automatic t_restart();
    logic a;
    m_start();
    m_send({OWN, 1'b1}, a);
    cpu_clr();
    cpu_write(8'hC3);
    m_start();
    chk("R9 repeated start clears tx_mode", tx_mode, 0);
    chk("R9 repeated start SDA released", sda_pull, 0);
    chk("R9 repeated start SCL released", scl_pull, 0);
    m_send({OWN, 1'b0}, a);
    chk("R9 new address phase acked", a, 0);
    chk("R9 new phase write mode", tx_mode, 0);
    cpu_write(8'h00);
    m_stop();
    cpu_clr();
  endtask

  initial begin
    rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
    data_wr = 1'b0; data = '0; force_tx = 1'b0; arb_lost = 1'b0; irq_clr = 1'b0;
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_idle_write();
    t_mismatch();
    t_read_two();
    t_write_dir();
    t_arb_lost();
    t_restart();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule